// File: doc/BRIEF.md
# Windowed Activation-Count Throttle Monitor

This block watches DRAM row-activate pulses for every DIMM pair on two memory branches. It counts them over a repeating sampling window and compares each pair's count with a programmable limit. When any pair on a branch goes past the limit, the block raises that branch's global-throttle flag. It also drives a per-branch select that tells the throttle actuator to use its intermediate setting.

The limit is an 8-bit value written through a simple write/read port. The stored value is clamped to 168, and a value of 0 turns throttling off. The real activation threshold is the limit scaled by a granularity that depends on the window mode. The normal window is 16384 prescaler periods with 65536 activations per limit unit. The debug window is 4 prescaler periods with 16 activations per limit unit. The prescaler period defaults to 1344 clock cycles.

A flag stays up until a whole window ends in which no pair on its branch went over the limit. Writing the limit or changing the mode starts a fresh window with all counters cleared.

Top module: `act_throttle_mon`

## Requirements
- R1: After reset the stored limit reads 0, and both throttle flags and both select outputs are 0.
- R2: A write stores min(wr_data, 168). rd_data returns the stored value from the cycle after the write.
- R3: With a stored limit of 0, no throttle flag is ever raised, whatever the activate rate.
- R4: In debug mode (dbg_mode=1) the threshold is 16 × limit. A flag is raised only when a pair's count is strictly above the threshold. It rises on the edge that follows the edge that registered the over-limit activate.
- R5: In normal mode (dbg_mode=0) the threshold is 65536 × limit, and the window is 16384 prescaler periods long.
- R6: Activates are counted per pair. Pulses on different pairs of one branch are never summed.
- R7: Activate bit act[b*NPAIR+p] belongs to pair p of branch b. Branch b's flag, thr_status[b], depends only on the pairs of branch b.
- R8: A raised flag holds through the end of the window in which the over-limit condition occurred. It clears at the first window boundary that closes a window with no over-limit pair on that branch. The debug window is 4 × PRESCALE cycles long.
- R9: A limit write, or a change of dbg_mode, clears all pair counters and restarts the window.
- R10: thr_mid_sel[b] is 1 exactly when thr_status[b] is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dbg_mode | input | 1 | 1 selects the short debug window, 0 the normal window |
| wr_en | input | 1 | Limit write strobe |
| wr_data | input | 8 | Limit value to write |
| rd_data | output | 8 | Stored (clamped) limit |
| act | input | NBR*NPAIR | Per-pair activate pulses, branch-major |
| thr_status | output | NBR | Per-branch global-throttle flag |
| thr_mid_sel | output | NBR | Per-branch select for the intermediate throttle setting |

## Verification
The hardest case to reach from the ports is the normal-mode threshold, which needs more than 65536 activates on one pair inside a single window. The bench shortens the prescaler to 5 cycles, which makes the normal window 81920 cycles long. It then drives one pair continuously for exactly 65536 cycles, confirms that no flag is raised, and adds one more pulse. Flag clearing is checked across two consecutive debug windows whose boundaries the bench counts from the restart edge of a limit write.

// File: rtl/act_throttle_mon.sv
module act_throttle_mon #(
  parameter int NBR        = 2,
  parameter int NPAIR      = 2,
  parameter int PRESCALE   = 1344,
  parameter int NORM_WIN   = 16384,
  parameter int DBG_WIN    = 4,
  parameter int NORM_SHIFT = 16,
  parameter int DBG_SHIFT  = 4,
  parameter int LIM_MAX    = 168
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   dbg_mode,
  input  logic                   wr_en,
  input  logic [7:0]             wr_data,
  output logic [7:0]             rd_data,
  input  logic [NBR*NPAIR-1:0]   act,
  output logic [NBR-1:0]         thr_status,
  output logic [NBR-1:0]         thr_mid_sel
);
  localparam int NP   = NBR * NPAIR;
  localparam int CW   = $clog2(LIM_MAX * (2 ** NORM_SHIFT) + 2);
  localparam int PW   = $clog2(PRESCALE + 1);
  localparam int WMAX = (NORM_WIN > DBG_WIN) ? NORM_WIN : DBG_WIN;
  localparam int WW   = $clog2(WMAX + 1);

  logic [7:0]    lim_q;
  logic          mode_q;
  logic [PW-1:0] pre_q;
  logic [WW-1:0] win_q;
  logic [CW-1:0] cnt_q [NP];
  logic [NP-1:0] over;
  logic [NBR-1:0] br_over, hit_q, thr_q;

  wire restart = wr_en | (dbg_mode != mode_q);
  wire tick    = pre_q == PW'(PRESCALE - 1);
  wire [WW-1:0] wlast = mode_q ? WW'(DBG_WIN - 1) : WW'(NORM_WIN - 1);
  wire wend    = tick && (win_q == wlast) && !restart;
  wire [CW-1:0] thresh = CW'(lim_q) << (mode_q ? DBG_SHIFT : NORM_SHIFT);
  wire [7:0] wr_lim = (wr_data > 8'(LIM_MAX)) ? 8'(LIM_MAX) : wr_data;

  assign rd_data     = lim_q;
  assign thr_status  = thr_q;
  assign thr_mid_sel = thr_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      lim_q  <= '0;
      mode_q <= 1'b0;
      pre_q  <= '0;
      win_q  <= '0;
    end else begin
      mode_q <= dbg_mode;
      if (wr_en) lim_q <= wr_lim;
      if (restart) begin
        pre_q <= '0;
        win_q <= '0;
      end else if (tick) begin
        pre_q <= '0;
        win_q <= wend ? '0 : win_q + 1'b1;
      end else begin
        pre_q <= pre_q + 1'b1;
      end
    end
  end

  for (genvar i = 0; i < NP; i++) begin : g_pair
    assign over[i] = (lim_q != 8'd0) && (cnt_q[i] > thresh);
    always_ff @(posedge clk) begin
      if (!rst_n)
        cnt_q[i] <= '0;
      else if (restart || wend)
        cnt_q[i] <= CW'(act[i]);
      else if (act[i] && (cnt_q[i] != '1))
        cnt_q[i] <= cnt_q[i] + 1'b1;
    end
  end

  for (genvar b = 0; b < NBR; b++) begin : g_br
    assign br_over[b] = |over[b*NPAIR +: NPAIR];
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hit_q <= '0;
      thr_q <= '0;
    end else begin
      hit_q <= (wend || restart) ? '0 : (hit_q | br_over);
      thr_q <= wend ? (hit_q | br_over) : (thr_q | br_over);
    end
  end
endmodule

// File: rtl/act_throttle_mon_chk.sv
module act_throttle_mon_chk #(
  parameter int NBR     = 2,
  parameter int PW      = 11,
  parameter int LIM_MAX = 168
) (
  input logic           clk,
  input logic           rst_n,
  input logic           wr_en,
  input logic [7:0]     wr_data,
  input logic [7:0]     rd_data,
  input logic [NBR-1:0] thr_status,
  input logic [NBR-1:0] thr_mid_sel,
  input logic           wend,
  input logic           restart,
  input logic [PW-1:0]  pre_q
);
  // R2
  limit_cap_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_data <= 8'(LIM_MAX));

  // R2
  write_clamp_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_en |=> rd_data == (($past(wr_data) > 8'(LIM_MAX)) ? 8'(LIM_MAX) : $past(wr_data)));

  // R9
  restart_window_chk: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> pre_q == '0);

  // R10
  sel_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    thr_mid_sel == thr_status);

  for (genvar b = 0; b < NBR; b++) begin : g_b
    // R8
    fall_at_boundary_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $fell(thr_status[b]) |-> $past(wend));
    // R3
    zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(thr_status[b]) |-> $past(rd_data) != 8'd0);
  end
endmodule

bind act_throttle_mon act_throttle_mon_chk #(.NBR(NBR), .PW(PW), .LIM_MAX(LIM_MAX)) u_chk (
  .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data),
  .thr_status(thr_status), .thr_mid_sel(thr_mid_sel), .wend(wend),
  .restart(restart), .pre_q(pre_q)
);

// File: tb/sim_act_throttle_mon.sv
module sim_act_throttle_mon;
  localparam int CLK_PERIOD = 10;
  localparam int NP = 4;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic dbg_mode = 1'b0;
  logic wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic [NP-1:0] act = '0;
  logic [7:0] rd_data;
  logic [1:0] thr_status, thr_mid_sel;
  int total = 0, bad = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  act_throttle_mon #(.PRESCALE(5)) u0 (
    .clk(clk), .rst_n(rst_n), .dbg_mode(dbg_mode), .wr_en(wr_en), .wr_data(wr_data),
    .rd_data(rd_data), .act(act), .thr_status(thr_status), .thr_mid_sel(thr_mid_sel)
  );

  task automatic check(input string req, input int got, input int exp);
    total++;
    if (got != exp) begin
      bad++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic wr(input logic [7:0] v);
    wr_en = 1'b1; wr_data = v;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic set_mode(input logic m);
    dbg_mode = m;
    @(negedge clk);
  endtask

  task automatic pulse(input logic [NP-1:0] m, input int n);
    act = m;
    repeat (n) @(negedge clk);
    act = '0;
  endtask

  task automatic t_reset;
    check("R1 limit", rd_data, 0);
    check("R1 status", thr_status, 0);
    check("R1 select", thr_mid_sel, 0);
  endtask

  task automatic t_clamp;
    wr(8'd200); check("R2 clamp 200", rd_data, 168);
    wr(8'd168); check("R2 keep 168", rd_data, 168);
    wr(8'd37);  check("R2 keep 37", rd_data, 37);
    wr(8'd255); check("R2 clamp 255", rd_data, 168);
  endtask

  task automatic t_zero;
    set_mode(1'b1);
    wr(8'd0);
    pulse(4'b1111, 19);
    step(1);
    check("R3 zero limit no throttle", thr_status, 0);
  endtask

  task automatic t_dbg_thresh;
    wr(8'd1);
    pulse(4'b0001, 16);
    step(1);
    check("R4 at threshold no throttle", thr_status, 0);
    pulse(4'b0001, 1);
    step(1);
    check("R4 above threshold sets", thr_status, 1);
    check("R10 select follows", thr_mid_sel, 1);
    step(20);
    check("R8 held through window", thr_status, 1);
    step(1);
    check("R8 cleared after clean window", thr_status, 0);
    check("R10 select clears", thr_mid_sel, 0);
  endtask

  task automatic t_pairs;
    wr(8'd1);
    pulse(4'b1100, 10);
    step(1);
    check("R6 pairs not summed", thr_status, 0);
    pulse(4'b0100, 7);
    step(1);
    check("R7 only branch 1 flagged", thr_status, 2);
    step(30);
    check("R8 branch 1 cleared", thr_status, 0);
  endtask

  task automatic t_restart;
    wr(8'd1);
    pulse(4'b0001, 12);
    wr(8'd1);
    pulse(4'b0001, 12);
    step(1);
    check("R9 write restarts counts", thr_status, 0);
    set_mode(1'b0);
    set_mode(1'b1);
    pulse(4'b0001, 12);
    step(1);
    check("R9 mode change restarts counts", thr_status, 0);
    pulse(4'b0001, 5);
    step(1);
    check("R9 counting resumes", thr_status, 1);
    step(45);
    check("R8 cleared before next test", thr_status, 0);
  endtask

  task automatic t_normal;
    set_mode(1'b0);
    wr(8'd1);
    pulse(4'b0001, 65536);
    step(1);
    check("R5 at normal threshold no throttle", thr_status, 0);
    pulse(4'b0001, 1);
    step(1);
    check("R5 above normal threshold sets", thr_status, 1);
  endtask

  initial begin
    step(3);
    rst_n = 1'b1;
    step(1);
    t_reset;
    t_clamp;
    t_zero;
    t_dbg_thresh;
    t_pairs;
    t_restart;
    t_normal;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    #(CLK_PERIOD * 150000);
    total++;
    bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule